// File: doc/BRIEF.md
# H-Bridge Gate Sequencer

This block turns a handful of slow control levels into the four gate-enable signals of an H-bridge: high-left, high-right, low-left and low-right. A master off level forces every gate off and beats every other input. When the bridge is enabled but the start-up level is still low, both low-side switches conduct. Once start-up is high, a drive-select input picks one of two running modes:
- In direct mode, the level of the bridge clock chooses one of the two diagonal pairs.
- In halving mode, the active pair flips on every high-to-low edge of the bridge clock. Each pair therefore conducts for half of a full output period.

The bridge clock is taken either from an external pin or from an internal oscillator tick, chosen by a select input. All asynchronous inputs pass through two-flop synchronizers on the system clock.

Every hand-over from one conducting pattern to a different one first turns all four gates off. That dead interval ends when a slope-done input reports that the switching half-bridge has finished its transition, but never before a minimum count of cycles. A maximum count forces the pending pattern on if no slope report arrives. Bridge-clock edges that occur inside a dead interval still update the requested pattern, and the latest request is applied when the interval ends.

Top module: `hbridge_gate_seq`

## Requirements
- R1: While the synchronized off input is high, all four gate outputs are low, regardless of start-up, drive-select, clock and slope inputs.
- R2: With off low and start-up low, the output pattern is low-left and low-right on, high-left and high-right off (gate vector {hl,hr,ll,lr} = 0011).
- R3: With off low, start-up high, drive-select high and bridge clock high, the pattern is high-right plus low-left (0110).
- R4: With off low, start-up high, drive-select high and bridge clock low, the pattern is high-left plus low-right (1001).
- R5: With drive-select low (halving mode), the diagonal pair flips only on a high-to-low bridge-clock transition; rising transitions leave it unchanged.
- R6: On each entry into halving mode the first pattern requested is high-left plus low-right (1001).
- R7: A change between two different conducting patterns always passes through at least one cycle with all gates low. A high-side gate and the low-side gate on the same leg are never on together.
- R8: If the slope-done input is already high, the dead interval lasts exactly MIN_GAP cycles. A slope report that arrives later ends the interval after MIN_GAP and before MAX_GAP cycles.
- R9: With no slope report, the dead interval lasts exactly MAX_GAP cycles, and the pending pattern is then driven.
- R10: Bridge-clock edges during a dead interval are not lost. The pattern driven when the interval ends reflects every edge seen so far, and the interval is not restarted by them.
- R11: Synchronous reset drives all gates low and clears the halving phase.
- R12: A change of mode inputs that needs no dead interval (entering or leaving all-off) appears on the gates exactly three system clocks later: two synchronizer stages plus the output register.
- R13: The bridge clock comes from the external clock input when the source select is high, and from the oscillator tick when it is low. The unselected source has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bridge_off_i | input | 1 | Master off level, highest priority |
| startup_i | input | 1 | Start-up level; low keeps both low sides on |
| direct_i | input | 1 | Drive select: high = direct mode, low = halving mode |
| ext_clk_i | input | 1 | External bridge clock |
| osc_tick_i | input | 1 | Internal oscillator bridge clock |
| ext_sel_i | input | 1 | Clock source select: high = external |
| slope_done_i | input | 1 | Half-bridge slope finished report |
| gate_hl_o | output | 1 | High-left gate enable |
| gate_hr_o | output | 1 | High-right gate enable |
| gate_ll_o | output | 1 | Low-left gate enable |
| gate_lr_o | output | 1 | Low-right gate enable |

## Verification
The assertions assume that every input, the bridge clock included, is driven to a known level from time zero. They also assume the bridge clock changes slowly enough relative to the system clock that both synchronized edges are seen. The halving-phase properties assume that the raw levels stay put during reset. The stimulus changes inputs only at falling system-clock edges and holds each bridge-clock level for at least three system cycles. It waits for every dead interval to complete before starting the next scenario, except in the one scenario that deliberately injects edges inside an interval.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

  // Conducting patterns the sequencer can hold
  typedef enum logic [1:0] {
    PAT_OFF    = 2'd0,
    PAT_LOWS   = 2'd1,
    PAT_DIAG_A = 2'd2,  // high-left + low-right
    PAT_DIAG_B = 2'd3   // high-right + low-left
  } pat_e;

  typedef enum logic {
    ST_RUN = 1'b0,
    ST_GAP = 1'b1
  } seq_st_e;

  // Gate vector order: {hl, hr, ll, lr}
  function automatic logic [3:0] pat_gates(input pat_e p);
    case (p)
      PAT_LOWS:   return 4'b0011;
      PAT_DIAG_A: return 4'b1001;
      PAT_DIAG_B: return 4'b0110;
      default:    return 4'b0000;
    endcase
  endfunction

  function automatic logic pat_conducts(input pat_e p);
    return p != PAT_OFF;
  endfunction

  // Dead interval completes after 'elapsed' off cycles (counted from 1)
  function automatic logic gap_done(input int unsigned elapsed,
                                    input logic slope,
                                    input int unsigned min_c,
                                    input int unsigned max_c);
    return ((elapsed >= min_c) && slope) || (elapsed >= max_c);
  endfunction

endpackage

// File: rtl/hbg_sync.sv
module hbg_sync #(
  parameter int unsigned WIDTH = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] stab_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= RST_VAL;
      stab_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;

  // Two-stage latency from raw input to synchronized output
  assert_sync_delay_R12: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2)) |-> (q_o == $past(d_i, 2)));

endmodule

// File: rtl/hbg_phase.sv
module hbg_phase
  import hbg_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bclk_s_i,
  input  logic div_active_i,
  output pat_e div_pat_o,
  output logic fall_o
);

  logic bclk_d_q;
  logic phase_q;     // 0: diagonal A, 1: diagonal B
  logic div_d_q;
  logic entry_w;

  assign fall_o  = bclk_d_q & ~bclk_s_i;
  assign entry_w = div_active_i & ~div_d_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_d_q <= 1'b0;
      phase_q  <= 1'b0;
      div_d_q  <= 1'b0;
    end else begin
      bclk_d_q <= bclk_s_i;
      div_d_q  <= div_active_i;
      if (entry_w)
        phase_q <= 1'b0;
      else if (div_active_i && fall_o)
        phase_q <= ~phase_q;
    end
  end

  assign div_pat_o = (entry_w || !phase_q) ? PAT_DIAG_A : PAT_DIAG_B;

  // Entry into halving mode always begins with diagonal A
  assert_entry_phase_R6: assert property (@(posedge clk) disable iff (rst)
    (div_active_i && !$past(div_active_i)) |-> (div_pat_o == PAT_DIAG_A));

  // Without a falling edge the pair stays put
  assert_hold_no_fall_R5: assert property (@(posedge clk) disable iff (rst)
    (div_active_i && $past(div_active_i) && !$past(fall_o))
      |-> (div_pat_o == $past(div_pat_o)));

  // A falling edge in steady halving mode flips the pair
  assert_flip_on_fall_R5: assert property (@(posedge clk) disable iff (rst)
    (div_active_i && $past(div_active_i) && $past(div_active_i, 2) && $past(fall_o))
      |-> (div_pat_o != $past(div_pat_o)));

endmodule

// File: rtl/hbg_mode_dec.sv
module hbg_mode_dec
  import hbg_pkg::*;
(
  input  logic off_s_i,
  input  logic startup_s_i,
  input  logic direct_s_i,
  input  logic bclk_s_i,
  input  pat_e div_pat_i,
  output logic div_active_o,
  output pat_e req_o
);

  assign div_active_o = !off_s_i && startup_s_i && !direct_s_i;

  always_comb begin
    if (off_s_i)
      req_o = PAT_OFF;
    else if (!startup_s_i)
      req_o = PAT_LOWS;
    else if (direct_s_i)
      req_o = bclk_s_i ? PAT_DIAG_B : PAT_DIAG_A;
    else
      req_o = div_pat_i;
  end

endmodule

// File: rtl/hbg_gap_seq.sv
module hbg_gap_seq
  import hbg_pkg::*;
#(
  parameter int unsigned MIN_GAP = 4,
  parameter int unsigned MAX_GAP = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  pat_e       req_i,
  input  logic       slope_s_i,
  output logic [3:0] gates_o,
  output logic       in_gap_o
);

  localparam int unsigned CNT_W = $clog2(MAX_GAP + 1);

  seq_st_e          state_q, state_n;
  pat_e             cur_q, cur_n;
  logic [CNT_W-1:0] gap_cnt_q, gap_cnt_n;
  logic [3:0]       gates_q, gates_n;
  logic             done_w;

  assign done_w = gap_done(32'(gap_cnt_q) + 32'd1, slope_s_i, MIN_GAP, MAX_GAP);

  always_comb begin
    state_n   = state_q;
    cur_n     = cur_q;
    gap_cnt_n = gap_cnt_q;
    case (state_q)
      ST_RUN: begin
        if (req_i == PAT_OFF) begin
          cur_n = PAT_OFF;
        end else if (req_i != cur_q) begin
          if (!pat_conducts(cur_q)) begin
            cur_n = req_i;
          end else begin
            state_n   = ST_GAP;
            gap_cnt_n = '0;
          end
        end
      end
      default: begin
        if (req_i == PAT_OFF) begin
          state_n = ST_RUN;
          cur_n   = PAT_OFF;
        end else if (done_w) begin
          state_n = ST_RUN;
          cur_n   = req_i;
        end else begin
          gap_cnt_n = gap_cnt_q + CNT_W'(1);
        end
      end
    endcase
    gates_n = (state_n == ST_GAP) ? 4'b0000 : pat_gates(cur_n);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_RUN;
      cur_q     <= PAT_OFF;
      gap_cnt_q <= '0;
      gates_q   <= 4'b0000;
    end else begin
      state_q   <= state_n;
      cur_q     <= cur_n;
      gap_cnt_q <= gap_cnt_n;
      gates_q   <= gates_n;
    end
  end

  assign gates_o  = gates_q;
  assign in_gap_o = (state_q == ST_GAP);

  // Leaving a dead interval into conduction only after the minimum
  assert_min_gap_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && $past(state_q) == ST_GAP && cur_q != PAT_OFF)
      |-> (32'($past(gap_cnt_q)) + 32'd1 >= MIN_GAP));

  // Interval counter never exceeds the timeout bound
  assert_gap_bound_R9: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_GAP) |-> (32'(gap_cnt_q) < MAX_GAP));

  // Pattern driven after the interval is the latest request
  assert_latest_req_R10: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && $past(state_q) == ST_GAP) |-> (cur_q == $past(req_i)));

endmodule

// File: rtl/hbridge_gate_seq.sv
module hbridge_gate_seq
  import hbg_pkg::*;
#(
  parameter int unsigned MIN_GAP = 4,
  parameter int unsigned MAX_GAP = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic bridge_off_i,
  input  logic startup_i,
  input  logic direct_i,
  input  logic ext_clk_i,
  input  logic osc_tick_i,
  input  logic ext_sel_i,
  input  logic slope_done_i,
  output logic gate_hl_o,
  output logic gate_hr_o,
  output logic gate_ll_o,
  output logic gate_lr_o
);

  localparam int unsigned N_SYNC = 5;
  // bit order: {off, startup, direct, bclk, slope}; off resets high
  localparam logic [N_SYNC-1:0] SYNC_RST = 5'b10000;

  logic              bclk_raw_w;
  logic [N_SYNC-1:0] raw_w;
  logic [N_SYNC-1:0] syn_w;
  logic              off_s, startup_s, direct_s, bclk_s, slope_s;
  logic              div_active_w;
  logic              fall_w;
  logic              in_gap_w;
  pat_e              div_pat_w;
  pat_e              req_w;
  logic [3:0]        gates_w;

  assign bclk_raw_w = ext_sel_i ? ext_clk_i : osc_tick_i;
  assign raw_w      = {bridge_off_i, startup_i, direct_i, bclk_raw_w, slope_done_i};

  hbg_sync #(.WIDTH(N_SYNC), .RST_VAL(SYNC_RST)) sync_i (
    .clk (clk),
    .rst (rst),
    .d_i (raw_w),
    .q_o (syn_w)
  );

  assign {off_s, startup_s, direct_s, bclk_s, slope_s} = syn_w;

  hbg_phase phase_i (
    .clk          (clk),
    .rst          (rst),
    .bclk_s_i     (bclk_s),
    .div_active_i (div_active_w),
    .div_pat_o    (div_pat_w),
    .fall_o       (fall_w)
  );

  hbg_mode_dec dec_i (
    .off_s_i      (off_s),
    .startup_s_i  (startup_s),
    .direct_s_i   (direct_s),
    .bclk_s_i     (bclk_s),
    .div_pat_i    (div_pat_w),
    .div_active_o (div_active_w),
    .req_o        (req_w)
  );

  hbg_gap_seq #(.MIN_GAP(MIN_GAP), .MAX_GAP(MAX_GAP)) seq_i (
    .clk       (clk),
    .rst       (rst),
    .req_i     (req_w),
    .slope_s_i (slope_s),
    .gates_o   (gates_w),
    .in_gap_o  (in_gap_w)
  );

  assign {gate_hl_o, gate_hr_o, gate_ll_o, gate_lr_o} = gates_w;

  // Master off forces every gate low on the next cycle
  assert_off_all_low_R1: assert property (@(posedge clk) disable iff (rst)
    off_s |=> (gates_w == 4'b0000));

  // No leg ever has both switches on
  assert_no_shoot_R7: assert property (@(posedge clk) disable iff (rst)
    !(gate_hl_o && gate_ll_o) && !(gate_hr_o && gate_lr_o));

  // Two conducting cycles in a row must show the same pattern
  assert_break_make_R7: assert property (@(posedge clk) disable iff (rst)
    (gates_w != 4'b0000 && $past(gates_w) != 4'b0000) |-> (gates_w == $past(gates_w)));

  // Outputs stay low while a dead interval is open
  assert_gap_low_R7: assert property (@(posedge clk) disable iff (rst)
    in_gap_w |-> (gates_w == 4'b0000));

endmodule

// File: tb/hbridge_gate_seq_tb.sv
module hbridge_gate_seq_tb_top;

  localparam time CLK_PERIOD = 10ns;
  localparam int  MIN_GAP = 4;
  localparam int  MAX_GAP = 16;

  localparam logic [3:0] G_OFF  = 4'b0000;
  localparam logic [3:0] G_LOWS = 4'b0011;
  localparam logic [3:0] G_A    = 4'b1001;
  localparam logic [3:0] G_B    = 4'b0110;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bridge_off = 1'b1;
  logic startup = 1'b0;
  logic direct = 1'b0;
  logic ext_clk = 1'b0;
  logic osc_tick = 1'b0;
  logic ext_sel = 1'b1;
  logic slope_done = 1'b1;
  logic hl, hr, ll, lr;
  logic [3:0] gates;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  hbridge_gate_seq #(.MIN_GAP(MIN_GAP), .MAX_GAP(MAX_GAP)) dut_i (
    .clk          (clk),
    .rst          (rst),
    .bridge_off_i (bridge_off),
    .startup_i    (startup),
    .direct_i     (direct),
    .ext_clk_i    (ext_clk),
    .osc_tick_i   (osc_tick),
    .ext_sel_i    (ext_sel),
    .slope_done_i (slope_done),
    .gate_hl_o    (hl),
    .gate_hr_o    (hr),
    .gate_ll_o    (ll),
    .gate_lr_o    (lr)
  );

  assign gates = {hl, hr, ll, lr};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Same-leg conduction monitor (R7)
  always @(negedge clk) begin
    if (!rst && ((hl && ll) || (hr && lr))) begin
      fails++;
      checks++;
      $display("FAIL R7: shoot-through actual %b expected no same-leg pair", gates);
    end
  end

  task automatic measure_gap(output int off_n, output logic [3:0] after_g);
    int guard = 0;
    off_n = 0;
    while (gates != G_OFF && guard < 30) begin @(negedge clk); guard++; end
    while (gates == G_OFF && off_n < 200) begin off_n++; @(negedge clk); end
    after_g = gates;
  endtask

  task automatic latency3(input logic [3:0] old_g, input logic [3:0] new_g, input string req);
    @(negedge clk);
    @(negedge clk);
    check(gates == old_g, req, gates, old_g);
    @(negedge clk);
    check(gates == new_g, req, gates, new_g);
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    check(gates == G_OFF, "R11 reset all-off", gates, G_OFF);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    check(gates == G_OFF, "R1 off after reset", gates, G_OFF);
  endtask

  task automatic t_off_and_startup();
    bridge_off = 1'b0; startup = 1'b0;
    latency3(G_OFF, G_LOWS, "R2/R12 lows on");
    bridge_off = 1'b1;
    latency3(G_LOWS, G_OFF, "R1/R12 off latency");
    startup = 1'b1; direct = 1'b1;
    for (int i = 0; i < 4; i++) begin
      ext_clk = ~ext_clk;
      repeat (4) @(negedge clk);
      check(gates == G_OFF, "R1 off overrides", gates, G_OFF);
    end
    ext_clk = 1'b0; startup = 1'b0;
    repeat (6) @(negedge clk);
    check(gates == G_OFF, "R1 off overrides startup", gates, G_OFF);
    bridge_off = 1'b0;
    latency3(G_OFF, G_LOWS, "R2/R12 lows after off");
  endtask

  task automatic t_direct();
    int n; logic [3:0] g;
    slope_done = 1'b1;
    startup = 1'b1; direct = 1'b1; ext_clk = 1'b0;
    measure_gap(n, g);
    check(n == MIN_GAP, "R8 min gap lows->A", n, MIN_GAP);
    check(g == G_A, "R4 direct clock low", g, G_A);
    @(negedge clk); ext_clk = 1'b1;
    measure_gap(n, g);
    check(n == MIN_GAP, "R8 min gap A->B", n, MIN_GAP);
    check(g == G_B, "R3 direct clock high", g, G_B);
  endtask

  task automatic t_divide();
    int n; logic [3:0] g;
    @(negedge clk); direct = 1'b0;
    measure_gap(n, g);
    check(g == G_A, "R6 halving entry phase", g, G_A);
    @(negedge clk); ext_clk = 1'b0;
    measure_gap(n, g);
    check(g == G_B, "R5 flip on falling edge", g, G_B);
    @(negedge clk); ext_clk = 1'b1;
    repeat (12) @(negedge clk);
    check(gates == G_B, "R5 rising edge ignored", gates, G_B);
    ext_clk = 1'b0;
    measure_gap(n, g);
    check(g == G_A, "R5 second falling edge", g, G_A);
  endtask

  task automatic t_timeout();
    int n; logic [3:0] g;
    @(negedge clk); slope_done = 1'b0; ext_clk = 1'b1;
    repeat (6) @(negedge clk);
    ext_clk = 1'b0;
    measure_gap(n, g);
    check(n == MAX_GAP, "R9 timeout length", n, MAX_GAP);
    check(g == G_B, "R9 pending pair driven", g, G_B);
  endtask

  task automatic t_slope_late();
    int n = 0; int guard = 0;
    @(negedge clk); slope_done = 1'b0; ext_clk = 1'b1;
    repeat (6) @(negedge clk);
    ext_clk = 1'b0;
    while (gates != G_OFF && guard < 30) begin @(negedge clk); guard++; end
    while (gates == G_OFF && n < 200) begin
      n++;
      if (n == 6) slope_done = 1'b1;
      @(negedge clk);
    end
    check(n > MIN_GAP && n < MAX_GAP, "R8 late slope ends gap", n, MIN_GAP + 1);
    check(gates == G_A, "R8 pair after late slope", gates, G_A);
  endtask

  task automatic t_latch();
    int n = 0; int guard = 0;
    @(negedge clk); slope_done = 1'b0; ext_clk = 1'b1;
    repeat (6) @(negedge clk);
    ext_clk = 1'b0;
    while (gates != G_OFF && guard < 30) begin @(negedge clk); guard++; end
    while (gates == G_OFF && n < 200) begin
      n++;
      if (n == 3) ext_clk = 1'b1;
      if (n == 6) ext_clk = 1'b0;
      @(negedge clk);
    end
    check(n == MAX_GAP, "R10 interval not restarted", n, MAX_GAP);
    check(gates == G_A, "R10 edge in gap applied", gates, G_A);
    slope_done = 1'b1;
    repeat (20) @(negedge clk);
    check(gates == G_A, "R10 pair settled", gates, G_A);
  endtask

  task automatic t_osc_source();
    int n; logic [3:0] g;
    @(negedge clk); ext_sel = 1'b0; osc_tick = 1'b0;
    repeat (4) @(negedge clk);
    ext_clk = 1'b1;
    repeat (6) @(negedge clk);
    ext_clk = 1'b0;
    repeat (12) @(negedge clk);
    check(gates == G_A, "R13 unselected clock ignored", gates, G_A);
    osc_tick = 1'b1;
    repeat (6) @(negedge clk);
    osc_tick = 1'b0;
    measure_gap(n, g);
    check(g == G_B, "R13 oscillator tick drives", g, G_B);
  endtask

  task automatic t_reset_phase();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    check(gates == G_OFF, "R11 reset forces off", gates, G_OFF);
    rst = 1'b0;
    repeat (10) @(negedge clk);
    check(gates == G_A, "R11 phase cleared by reset", gates, G_A);
  endtask

  initial begin
    t_reset();
    t_off_and_startup();
    t_direct();
    t_divide();
    t_timeout();
    t_slope_late();
    t_latch();
    t_osc_source();
    t_reset_phase();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule